// File: doc/BRIEF.md
# Endpoint Packet-Size Table with Buffer Allocator

This block keeps one maximum packet size for each of 32 physical endpoints and turns those sizes into buffer start addresses in a shared packet RAM. Software reaches the table through two registers behind one write port: an endpoint selector, which can only be written, and a size register, which is written and read at the entry the selector points to. The size of the currently selected entry is always visible on a read-data output.

Every write to the size register launches an allocation pass. The pass visits the endpoints one per clock, from endpoint 0 upward. Each endpoint gets as its base the running total of the buffers below it, counted in 32-bit words. A new size write during a pass restarts it from endpoint 0. Only a pass that runs to the end sets the "realized" flag. Software clears that flag with a one-cycle clear strobe. The other logic of the chip reads base addresses through a lookup port. It must treat them as unsettled while `busy` is high.

There is no data stream at this block's edge. The register port accepts a write on every cycle it is strobed and never pushes back, so no valid/ready handshake is used, and every control and status pin is plain.

Top module: `ep_size_alloc`

## Requirements
- R1: After reset, entry 0 holds 8 and entries 1 to 31 hold 0. The selector is 0. `busy` and `realized` are 0. The lookup shows base 0 for endpoint 0 and base 2 (words) for every other endpoint.
- R2: A write with `reg_sel`=0 stores `reg_wdata[4:0]` as the selected endpoint. It changes no table entry and does not start a pass, so `busy` stays 0.
- R3: A write with `reg_sel`=1 stores `reg_wdata[9:0]` into the selected entry. From the next cycle on, `size_rdata` shows the entry at the current selector.
- R4: A size write raises `busy` from the next cycle on. With no further size write, `busy` stays high for exactly 32 cycles.
- R5: When a pass ends, the base of endpoint e is the sum, over every endpoint j below e, of ceil(size_j / 4), in words. An endpoint of size 0 adds nothing and takes the running total as its base. Bases do not change while `busy` is low.
- R6: A size write during a pass updates its entry and restarts the pass from endpoint 0. `busy` then falls 32 cycles after the last such write, and the bases reflect the final table.
- R7: `realized` is set in the cycle `busy` falls at the end of a completed pass and is 0 whenever `busy` is high. A size write clears it. A `realize_clr` pulse clears it, except in the cycle a pass completes, where setting wins.
- R8: `lookup_base` shows, without a clock delay, the stored base of the endpoint on `lookup_ep`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = endpoint selector, 1 = size register |
| reg_wdata | input | 10 | Write data (selector uses bits 4:0) |
| size_rdata | output | 10 | Size stored at the selected entry |
| realize_clr | input | 1 | Clear strobe for `realized` |
| lookup_ep | input | 5 | Endpoint whose base is looked up |
| lookup_base | output | 14 | Base address of `lookup_ep`, in 32-bit words |
| busy | output | 1 | Allocation pass in progress |
| realized | output | 1 | Last pass completed without a restart |

## Verification
A walker pointer or running total that goes wrong shows up only at the lookup port, as bad bases once `busy` falls. So the bench compares all 32 bases against its own running sum at the end of each pass, within 33 cycles of the write. A restart or completion fault changes the length of the `busy` window, which the bench measures to the cycle. It also shows up as a `realized` value that is set too early, not set at all, or cleared by a strobe it should override. A wrong table write shows on `size_rdata` one cycle later.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
  localparam int NUM_EP_DEF   = 32;
  localparam int SIZE_W_DEF   = 10;
  localparam int WORD_B_DEF   = 4;
  localparam int CTRL_RST_DEF = 8;

  typedef enum logic {
    SEL_INDEX = 1'b0,
    SEL_SIZE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/ep_size_table.sv
module ep_size_table #(
  parameter int NUM_EP   = 32,
  parameter int SIZE_W   = 10,
  parameter int EP_W     = 5,
  parameter int CTRL_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_wr,
  input  logic              size_wr,
  input  logic [SIZE_W-1:0] wdata,
  input  logic [EP_W-1:0]   walk_ep,
  output logic [SIZE_W-1:0] sel_size,
  output logic [SIZE_W-1:0] walk_size
);
  logic [EP_W-1:0]                idx_q;
  logic [NUM_EP-1:0][SIZE_W-1:0]  entries;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NUM_EP; i++)
        entries[i] <= (i == 0) ? SIZE_W'(CTRL_RST) : '0;
    end else begin
      if (idx_wr)
        idx_q <= wdata[EP_W-1:0];
      if (size_wr)
        entries[idx_q] <= wdata;
    end
  end

  assign sel_size  = entries[idx_q];
  assign walk_size = entries[walk_ep];

  AST_INDEX_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_wr && !size_wr) |=> $stable(entries)); // R2

  AST_SIZE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> entries[$past(idx_q)] == $past(wdata)); // R3
endmodule

// File: rtl/ep_base_walker.sv
module ep_base_walker #(
  parameter int NUM_EP   = 32,
  parameter int SIZE_W   = 10,
  parameter int EP_W     = 5,
  parameter int ADDR_W   = 14,
  parameter int WORD_B   = 4,
  parameter int CTRL_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr,
  input  logic [SIZE_W-1:0] ep_size,
  input  logic [EP_W-1:0]   lookup_ep,
  output logic [EP_W-1:0]   ptr,
  output logic [ADDR_W-1:0] lookup_base,
  output logic              busy,
  output logic              realized
);
  localparam int              WB_SHIFT  = $clog2(WORD_B);
  localparam int              RST_WORDS = (CTRL_RST + WORD_B - 1) / WORD_B;
  localparam logic [EP_W-1:0] LAST_EP   = EP_W'(NUM_EP - 1);

  logic [NUM_EP-1:0][ADDR_W-1:0] bases;
  logic [ADDR_W-1:0]             acc;
  logic [SIZE_W:0]               rounded;
  logic [ADDR_W-1:0]             step;

  always_comb begin
    rounded = {1'b0, ep_size} + (SIZE_W+1)'(WORD_B - 1);
    step    = ADDR_W'(rounded >> WB_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      realized <= 1'b0;
      ptr      <= '0;
      acc      <= '0;
      for (int i = 0; i < NUM_EP; i++)
        bases[i] <= (i == 0) ? '0 : ADDR_W'(RST_WORDS);
    end else if (start) begin
      busy     <= 1'b1;
      realized <= 1'b0;
      ptr      <= '0;
      acc      <= '0;
    end else if (busy) begin
      bases[ptr] <= acc;
      acc        <= acc + step;
      ptr        <= ptr + 1'b1;
      if (ptr == LAST_EP) begin
        busy     <= 1'b0;
        realized <= 1'b1;
      end
    end else if (clr) begin
      realized <= 1'b0;
    end
  end

  assign lookup_base = bases[lookup_ep];

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && ptr == '0)); // R6

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> realized); // R7

  AST_FLAG_LOW_IN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !realized); // R7

  AST_IDLE_BASES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(bases)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> acc >= $past(acc)); // R5
endmodule

// File: rtl/ep_size_alloc.sv
module ep_size_alloc
  import ep_alloc_pkg::*;
#(
  parameter int NUM_EP   = NUM_EP_DEF,
  parameter int SIZE_W   = SIZE_W_DEF,
  parameter int WORD_B   = WORD_B_DEF,
  parameter int CTRL_RST = CTRL_RST_DEF,
  parameter int EP_W     = $clog2(NUM_EP),
  parameter int ADDR_W   = $clog2(NUM_EP * ((2**SIZE_W + WORD_B - 2) / WORD_B) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [SIZE_W-1:0] reg_wdata,
  output logic [SIZE_W-1:0] size_rdata,
  input  logic              realize_clr,
  input  logic [EP_W-1:0]   lookup_ep,
  output logic [ADDR_W-1:0] lookup_base,
  output logic              busy,
  output logic              realized
);
  logic              idx_wr;
  logic              size_wr;
  logic [EP_W-1:0]   walk_ep;
  logic [SIZE_W-1:0] walk_size;

  assign idx_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_INDEX);
  assign size_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_SIZE);

  ep_size_table #(
    .NUM_EP(NUM_EP), .SIZE_W(SIZE_W), .EP_W(EP_W), .CTRL_RST(CTRL_RST)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_wr    (idx_wr),
    .size_wr   (size_wr),
    .wdata     (reg_wdata),
    .walk_ep   (walk_ep),
    .sel_size  (size_rdata),
    .walk_size (walk_size)
  );

  ep_base_walker #(
    .NUM_EP(NUM_EP), .SIZE_W(SIZE_W), .EP_W(EP_W), .ADDR_W(ADDR_W),
    .WORD_B(WORD_B), .CTRL_RST(CTRL_RST)
  ) u_walker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (size_wr),
    .clr         (realize_clr),
    .ep_size     (walk_size),
    .lookup_ep   (lookup_ep),
    .ptr         (walk_ep),
    .lookup_base (lookup_base),
    .busy        (busy),
    .realized    (realized)
  );

  AST_INDEX_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && idx_wr) |=> !busy); // R2

  AST_WRITE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    size_wr |=> (busy && !realized)); // R4
endmodule

// File: tb/ep_size_alloc_bench.sv
module ep_size_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [9:0]  reg_wdata = '0;
  logic [9:0]  size_rdata;
  logic        realize_clr = 1'b0;
  logic [4:0]  lookup_ep = '0;
  logic [13:0] lookup_base;
  logic        busy;
  logic        realized;

  int checks = 0;
  int failures = 0;
  int model [32];

  always #4 clk = ~clk;

  ep_size_alloc u_ep_size_alloc (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .size_rdata(size_rdata), .realize_clr(realize_clr),
    .lookup_ep(lookup_ep), .lookup_base(lookup_base), .busy(busy),
    .realized(realized)
  );

  // {endpoint, size}
  localparam logic [14:0] VEC [8] = '{
    {5'd1,  10'd64},  {5'd2,  10'd1},  {5'd3, 10'd5},  {5'd31, 10'd1023},
    {5'd0,  10'd0},   {5'd5,  10'd3},  {5'd4, 10'd4},  {5'd2,  10'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_base(input int e);
    int a = 0;
    for (int j = 0; j < e; j++) a += (model[j] + 3) / 4;
    return a;
  endfunction

  task automatic do_write(input logic sel, input int data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = 10'(data);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic check_bases(input string tag);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    for (int e = 0; e < 32; e++) begin
      lookup_ep = 5'(e);
      #1;
      if (int'(lookup_base) != exp_base(e) && bad == 0) begin
        first_act = int'(lookup_base); first_exp = exp_base(e);
      end
      if (int'(lookup_base) != exp_base(e)) bad++;
    end
    chk(bad == 0, tag, first_act, first_exp);
  endtask

  task automatic run_pass(input int ep, input int sz);
    do_write(1'b0, ep);
    do_write(1'b1, sz);
    model[ep] = sz;
    chk(size_rdata == 10'(sz), "R3 size readback", int'(size_rdata), sz);
    chk(busy == 1'b1, "R4 busy after write", int'(busy), 1);
    repeat (31) @(negedge clk);
    chk(busy == 1'b1, "R4 busy through cycle 32", int'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R4 busy falls after 32", int'(busy), 0);
    chk(realized == 1'b1, "R7 realized at end", int'(realized), 1);
    check_bases("R5 R8 bases after pass");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = (i == 0) ? 8 : 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(size_rdata == 10'd8, "R1 entry0 reset", int'(size_rdata), 8);
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(realized == 1'b0, "R1 realized reset", int'(realized), 0);
    check_bases("R1 reset bases");

    // R2 selector write only
    do_write(1'b0, 7);
    chk(busy == 1'b0, "R2 no pass on index write", int'(busy), 0);
    chk(size_rdata == 10'd0, "R2 entry7 untouched", int'(size_rdata), 0);
    do_write(1'b0, 0);
    chk(size_rdata == 10'd8, "R2 entry0 untouched", int'(size_rdata), 8);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 still idle", int'(busy), 0);

    // Vector walk
    for (int v = 0; v < 8; v++)
      run_pass(int'(VEC[v][14:10]), int'(VEC[v][9:0]));

    // R6 restart, R7 set-beats-clear and clear on start
    do_write(1'b0, 9);
    do_write(1'b1, 40);
    chk(realized == 1'b0, "R7 cleared by size write", int'(realized), 1'b0);
    repeat (9) @(negedge clk);
    do_write(1'b1, 12);
    model[9] = 12;
    chk(busy == 1'b1, "R6 busy after restart", int'(busy), 1);
    repeat (31) @(negedge clk);
    chk(busy == 1'b1, "R6 busy extended", int'(busy), 1);
    realize_clr = 1'b1;
    @(negedge clk);
    realize_clr = 1'b0;
    chk(busy == 1'b0, "R6 busy falls 32 after last write", int'(busy), 0);
    chk(realized == 1'b1, "R7 set wins over clear", int'(realized), 1);
    check_bases("R6 bases after restart");

    // R7 clear strobe when idle
    @(negedge clk);
    realize_clr = 1'b1;
    @(negedge clk);
    realize_clr = 1'b0;
    chk(realized == 1'b0, "R7 clear strobe", int'(realized), 0);
    check_bases("R5 bases hold while idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule